// File: doc/BRIEF.md
# Two-Stage Latched Crosspoint Datapath

This block carries an N-bit primary bus through a crosspoint selector to an N-bit output bus, with a level-sensitive latch on each side of the selector. The input stage is governed by a master enable clock. It stays open while that clock is high and closes on its falling edge. The output stage is governed by a slave enable clock in the same way. The output stage stores the selector result. The selector can pick a bit of the latched primary bus or a bit of a second expansion bus. The expansion bus skips the input stage and is sampled only by the output stage. This lets several such blocks be cascaded into a wider switch.

The routing is set by an external configuration word that holds one selector field per output. The clock levels alone choose the mode. With non-overlapping master and slave pulses the path acts as a two-stage pipeline. If both clocks are held high, both latches stay open and the path becomes a flow-through connection from input to output.

Top module: `xbar_latched_datapath`

## Requirements
- R1: While `rst_n` is low both latch stages are cleared and `dout` is all zeros, whatever the clock levels.
- R2: The input stage follows `din` while `mclk` is high and keeps the value present at the falling edge of `mclk` for as long as `mclk` stays low.
- R3: The output stage follows the selector result while `sclk` is high and keeps the value present at the falling edge of `sclk`; `dout` does not change while `sclk` is low.
- R4: Output `o` is routed by the field `cfg_word[o*SELW +: SELW]`, where SELW = log2(N)+1. When the top bit of the field is 0, the field's low log2(N) bits are the index of the latched primary bit that drives output `o`.
- R5: When the top bit of a field is 1, the low bits index the `xdin` bus. That bit enters the output stage directly, so it is captured at the falling edge of `sclk` and not by `mclk`.
- R6: When `mclk` and `sclk` are both high, a change on `din` or `xdin` reaches `dout` with no clock edge.
- R7: Any number of outputs may select the same input bit at once.
- R8: A change of `cfg_word` while `sclk` is low leaves `dout` unchanged. The new routing appears once `sclk` goes high.
- R9: A change of `din` while `mclk` is low does not reach `dout`, even while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of both latch stages |
| mclk | input | 1 | Master enable clock: input stage open while high |
| sclk | input | 1 | Slave enable clock: output stage open while high |
| din | input | N | Primary data bus |
| xdin | input | N | Expansion data bus, sampled by the output stage only |
| cfg_word | input | N*SELW | Active routing word, one SELW-bit field per output |
| dout | output | N | Switched output bus |

## Verification
Two functions can fall in the same cycle: capture by the input stage and propagation through the output stage. This happens in flow-through mode, where both clocks are held high. In that state a new `din` value must pass through both stages and the selector before any clock edge, and the bench judges `dout` against the bit the configuration names. The other overlap is a routing change and a slave-open window. The bench changes `cfg_word` while `sclk` is low, confirms that `dout` holds, then opens `sclk` and expects the new mapping. Every expected value is computed in the bench from the configuration fields and the captured data.

// File: rtl/xbar_dp_pkg.sv
`timescale 1ns/1ps
package xbar_dp_pkg;
    localparam int unsigned XDP_DEFAULT_PORTS = 32;

    // Selector field width: index bits plus one bus-select bit.
    function automatic int unsigned xdp_sel_width(input int unsigned ports);
        return $clog2(ports) + 1;
    endfunction
endpackage

// File: rtl/xdp_stage_latch.sv
`timescale 1ns/1ps
module xdp_stage_latch #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = d_i;
    end

    // Open while en is high; the falling edge of en is the closing edge.
    always_latch begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.data;

    // Checker state: the value present when the stage closed.
    logic [WIDTH-1:0] held_q;
    logic             armed_q;
    always_ff @(negedge en or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            held_q  <= q_o;
            armed_q <= 1'b1;
        end
    end

    // R2 (input stage) / R3 (output stage): just before closing, the stage matches its input.
    p_open_follow_r2: assert property (@(negedge en) disable iff (!rst_n)
        q_o == d_i);

    // R2 / R3: while closed, the stored value does not move.
    p_closed_hold_r3: assert property (@(posedge en) disable iff (!rst_n || !armed_q)
        q_o == held_q);
endmodule

// File: rtl/xdp_selector.sv
`timescale 1ns/1ps
module xdp_selector #(
    parameter int unsigned PORTS = 32,
    parameter int unsigned SELW  = 6
) (
    input  logic [PORTS-1:0]      prim_i,
    input  logic [PORTS-1:0]      exp_i,
    input  logic [PORTS*SELW-1:0] cfg_i,
    output logic [PORTS-1:0]      route_o
);
    localparam int unsigned IDXW = SELW - 1;

    logic [PORTS-1:0] route_d;

    for (genvar o = 0; o < PORTS; o++) begin : g_out
        logic [SELW-1:0] field_d;
        logic [IDXW-1:0] idx_d;
        always_comb begin
            field_d = cfg_i[o*SELW +: SELW];
            idx_d   = field_d[IDXW-1:0];
            route_d[o] = field_d[SELW-1] ? exp_i[idx_d] : prim_i[idx_d];
        end
    end

    assign route_o = route_d;
endmodule

// File: rtl/xbar_latched_datapath.sv
`timescale 1ns/1ps
module xbar_latched_datapath
    import xbar_dp_pkg::*;
#(
    parameter int unsigned N    = XDP_DEFAULT_PORTS,
    parameter int unsigned SELW = xdp_sel_width(N)
) (
    input  logic              rst_n,
    input  logic              mclk,
    input  logic              sclk,
    input  logic [N-1:0]      din,
    input  logic [N-1:0]      xdin,
    input  logic [N*SELW-1:0] cfg_word,
    output logic [N-1:0]      dout
);
    localparam int unsigned IDXW = SELW - 1;

    logic [N-1:0] prim_q;
    logic [N-1:0] route_d;

    xdp_stage_latch #(.WIDTH(N)) i_master (
        .rst_n (rst_n),
        .en    (mclk),
        .d_i   (din),
        .q_o   (prim_q)
    );

    xdp_selector #(.PORTS(N), .SELW(SELW)) i_sel (
        .prim_i  (prim_q),
        .exp_i   (xdin),
        .cfg_i   (cfg_word),
        .route_o (route_d)
    );

    xdp_stage_latch #(.WIDTH(N)) i_slave (
        .rst_n (rst_n),
        .en    (sclk),
        .d_i   (route_d),
        .q_o   (dout)
    );

    // R5: an expansion-routed output equals the named xdin bit at slave close.
    for (genvar o = 0; o < N; o++) begin : g_chk
        p_exp_route_r5: assert property (@(negedge sclk) disable iff (!rst_n)
            cfg_word[o*SELW+SELW-1] |-> dout[o] == xdin[cfg_word[o*SELW +: IDXW]]);
    end

    // R1: cleared output when reset is released.
    p_reset_clear_r1: assert property (@(posedge rst_n) dout == '0);
endmodule

// File: tb/test_xbar_latched_datapath.sv
`timescale 1ns/1ps
module test_xbar_latched_datapath;
    localparam int N    = 8;
    localparam int SELW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mclk = 1'b0;
    logic            sclk = 1'b0;
    logic [N-1:0]    din = '0;
    logic [N-1:0]    xdin = '0;
    logic [N*SELW-1:0] cfg_word = '0;
    logic [N-1:0]    dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    xbar_latched_datapath #(.N(N), .SELW(SELW)) i_xbar_latched_datapath (
        .rst_n(rst_n), .mclk(mclk), .sclk(sclk), .din(din),
        .xdin(xdin), .cfg_word(cfg_word), .dout(dout)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [N-1:0] route(input logic [N*SELW-1:0] c,
                                           input logic [N-1:0] d,
                                           input logic [N-1:0] x);
        logic [N-1:0] r;
        for (int o = 0; o < N; o++) begin
            int f;
            f = int'(c[o*SELW +: SELW]);
            r[o] = (f >= N) ? x[f - N] : d[f % N];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Non-overlapping pulses: master captures d, slave captures routed result with x.
    task automatic sync_cycle(input logic [N-1:0] d, input logic [N-1:0] x);
        din = d;  #1 mclk = 1'b1; #2 mclk = 1'b0;
        #1 din = ~d; xdin = x;
        #1 sclk = 1'b1; #2 sclk = 1'b0;
        #1 xdin = ~x; #1;
    endtask

    initial begin
        logic [N-1:0] d, x, prev;
        // R1: reset clears even with both stages open
        mclk = 1'b1; sclk = 1'b1; din = 8'hFF; xdin = 8'hFF; cfg_word = '0;
        #3 check("R1", dout, '0);
        mclk = 1'b0; sclk = 1'b0;
        #2 rst_n = 1'b1;
        #2 check("R1", dout, '0);

        // R4 R5 R7: broadcast every field value to all outputs
        for (int s = 0; s < 2*N; s++) begin
            for (int o = 0; o < N; o++) cfg_word[o*SELW +: SELW] = SELW'(s);
            d = N'(8'hA5 ^ (s * 37));
            x = N'(8'h3C ^ (s * 91));
            sync_cycle(d, x);
            check(s < N ? "R4 R7" : "R5 R7", dout, route(cfg_word, d, x));
            // R3: hold while sclk low with inputs moving
            din = x; xdin = d; #2;
            check("R3", dout, route(cfg_word, d, x));
        end

        // R4 R5: mixed rotated maps
        for (int r = 0; r < N; r++) begin
            for (int o = 0; o < N; o++)
                cfg_word[o*SELW +: SELW] = SELW'(((o % 2) * N) + ((o + r) % N));
            d = N'(1 << r) ^ 8'h5A;
            x = N'(8'hC3 + r * 13);
            sync_cycle(d, x);
            check("R4 R5", dout, route(cfg_word, d, x));
        end

        // R8: configuration change while sclk low has no effect until sclk opens
        for (int o = 0; o < N; o++) cfg_word[o*SELW +: SELW] = SELW'(o);
        d = 8'h96; x = 8'h0F;
        sync_cycle(d, x);
        prev = dout;
        check("R4", prev, d);
        for (int o = 0; o < N; o++) cfg_word[o*SELW +: SELW] = SELW'(N - 1 - o);
        #2 check("R8", dout, prev);
        sclk = 1'b1; #2;
        check("R8", dout, route(cfg_word, d, xdin));
        sclk = 1'b0; #1;

        // R9: din moves while mclk low and sclk high; output keeps captured data
        sclk = 1'b1; #1;
        din = 8'h00; #2;
        check("R9", dout, route(cfg_word, d, xdin));
        din = 8'hFF; #2;
        check("R9", dout, route(cfg_word, d, xdin));
        sclk = 1'b0; #1;

        // R6: flow-through with both clocks high
        for (int o = 0; o < N; o++) cfg_word[o*SELW +: SELW] = SELW'((o * 3) % N);
        cfg_word[7*SELW +: SELW] = SELW'(N + 2);
        mclk = 1'b1; sclk = 1'b1;
        for (int k = 0; k < 6; k++) begin
            d = N'(8'h11 * k + 8'h07);
            x = N'(k * 5);
            din = d; xdin = x; #1;
            check("R6", dout, route(cfg_word, d, x));
        end
        mclk = 1'b0; #1 sclk = 1'b0; #1;

        // R2: master closes at falling edge, later din ignored through a slave pulse
        d = 8'h6B;
        din = d; mclk = 1'b1; #2 mclk = 1'b0; #1 din = 8'h94;
        sclk = 1'b1; #2 sclk = 1'b0; #1;
        check("R2", dout, route(cfg_word, d, xdin));

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule